// File: doc/BRIEF.md
# Folded 4/8-Branch Feistel Datapath

This block is a 32-bit folded datapath for a 128-bit generalized Feistel block cipher. It runs a 4-branch network (four 32-bit words) to encrypt a data block, or an 8-branch network (eight 32-bit words) to derive intermediate key material from a longer key. Words enter one per cycle on a 32-bit bus. Each round applies the two nonlinear functions, called F0 and F1 here, to the even words and XORs each result into the odd word that follows.

The nonlinear functions sit outside the block behind a lookup port with one register of latency, so no substitution tables live inside. Round keys are fetched in order through an index/request port and are answered in the same cycle. The four working words are held in an addressable register store. The store is read through a rotating base pointer, so the word rotation between rounds costs no data movement.

The final whitening is applied in a separate output register stage. This lets a new block start loading in the same cycle that the previous block drains.

Top module: `gfn_fold_core`

## Requirements
- R1: After reset, busy_o, done_o, rk_req_o and f_req_o are 0, and out_a_o and out_b_o are all zero.
- R2: start_i is taken together with word 0 on din_i. Words 1 to n-1 follow on the next cycles, one per cycle, with n = 4 when mode8_i = 0 and n = 8 when mode8_i = 1. In 4-branch mode, word 1 is XORed with wk0_i and word 3 with wk1_i as they are loaded.
- R3: A 4-branch round XORs F0(word0 ^ key) into word 1 and F1(word2 ^ key) into word 3. It then rotates the words left by one position, except in the last round. After the last round, word 1 is XORed with wk2_i and word 3 with wk3_i. out_a_o carries word 0 in bits 127:96 down to word 3 in bits 31:0.
- R4: An 8-branch round applies F0, F1, F0, F1 to words 0, 2, 4, 6 and XORs each result into words 1, 3, 5, 7. It then rotates left by one word, except in the last round. No whitening is applied. out_a_o carries words 0 to 3 and out_b_o carries words 4 to 7, each with the lowest word index in the top bits.
- R5: The round count is set by ksel_i at start: 0 gives 18 rounds, 1 gives 22 rounds, and 2 or 3 give 26 rounds.
- R6: Each F call raises rk_req_o and f_req_o for one cycle. rk_idx_o counts 0, 1, 2 and so on, without gaps, one index per call. rk_i is used in the same cycle, and f_arg_o equals the even word XOR rk_i. f_sel_o is 0 for F0 and 1 for F1. f_res_i is expected one cycle after the request.
- R7: If start is taken in cycle 0, done_o is high for exactly one cycle, in cycle n + R*n/2 + 1. The outputs are valid from that cycle and hold until the next result.
- R8: busy_o is high from the cycle after start until the drain cycle. A start_i pulse during loading or rounds is ignored.
- R9: A start given in the drain cycle, which is the cycle just before done_o, is accepted. Both the finishing block and the new block give correct results.
- R10: In 4-branch mode, out_b_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a block; qualifies word 0 |
| mode8_i | input | 1 | 1 selects 8-branch, 0 selects 4-branch |
| ksel_i | input | 2 | Round count select |
| din_i | input | 32 | Data word bus |
| wk0_i | input | 32 | Pre-whitening key for word 1 |
| wk1_i | input | 32 | Pre-whitening key for word 3 |
| wk2_i | input | 32 | Post-whitening key for word 1 |
| wk3_i | input | 32 | Post-whitening key for word 3 |
| rk_req_o | output | 1 | Round key request |
| rk_idx_o | output | 7 | Round key index |
| rk_i | input | 32 | Round key, same cycle |
| f_req_o | output | 1 | F lookup request |
| f_sel_o | output | 1 | 0 = F0, 1 = F1 |
| f_arg_o | output | 32 | F lookup argument |
| f_res_i | input | 32 | F lookup result, one cycle later |
| busy_o | output | 1 | Block in progress |
| done_o | output | 1 | One-cycle result strobe |
| out_a_o | output | 128 | Words 0..3 of the result |
| out_b_o | output | 128 | Words 4..7 of the result (8-branch) |

## Verification
Both modes are swept over every round-count setting, each with several data patterns: all zeros, all ones, counting words and walking bits. All-zero data shows that the round keys and F results alone drive the output. The walking and counting patterns expose any misplaced word in the rotation or the output packing, and per-pattern whitening keys separate the pre- and post-whitening words. Separate runs inject a stray start during rounds, and an overlapped start in the drain cycle, to show that the first is ignored and the second is taken without corrupting either block.

// File: rtl/gfn_pkg.sv
package gfn_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_RUN   = 2'd2,
    ST_DRAIN = 2'd3
  } gfn_state_e;
endpackage

// File: rtl/gfn_word_store.sv
// Addressable word store: one load port, one XOR-update port, one read port.
module gfn_word_store #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ld_en,
  input  logic [IDX_W-1:0]             ld_idx,
  input  logic [WORD_W-1:0]            ld_data,
  input  logic                         xor_en,
  input  logic [IDX_W-1:0]             xor_idx,
  input  logic [WORD_W-1:0]            xor_data,
  input  logic [IDX_W-1:0]             rd_idx,
  output logic [WORD_W-1:0]            rd_data,
  output logic [DEPTH-1:0][WORD_W-1:0] all_o
);

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    logic              hit_ld;
    logic              wr_en;
    logic [WORD_W-1:0] nxt_w;
    logic [WORD_W-1:0] cur_q;

    always_comb begin
      hit_ld = ld_en && (ld_idx == IDX_W'(g));
      wr_en  = hit_ld || (xor_en && (xor_idx == IDX_W'(g)));
      nxt_w  = hit_ld ? ld_data : (cur_q ^ xor_data);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cur_q <= '0;
      end else if (wr_en) begin
        cur_q <= nxt_w;
      end
    end

    assign all_o[g] = cur_q;
  end

  assign rd_data = all_o[rd_idx];

endmodule

// File: rtl/gfn_sched.sv
// Round scheduler: load counting, issue slots, rotation base and key index.
module gfn_sched
  import gfn_pkg::*;
#(
  parameter int unsigned MAX_WORDS = 8,
  parameter int unsigned RND_SHORT = 18,
  parameter int unsigned RND_MID   = 22,
  parameter int unsigned RND_LONG  = 26,
  localparam int unsigned IDX_W  = $clog2(MAX_WORDS),
  localparam int unsigned HALF_W = $clog2(MAX_WORDS/2),
  localparam int unsigned RND_W  = $clog2(RND_LONG),
  localparam int unsigned RK_W   = $clog2(RND_LONG*MAX_WORDS/2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             mode8_i,
  input  logic [1:0]       ksel_i,
  output logic             m8_o,
  output logic             busy_o,
  output logic             ld_en_o,
  output logic [IDX_W-1:0] ld_idx_o,
  output logic             iss_en_o,
  output logic             sel_o,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic [RK_W-1:0]  rk_idx_o,
  output logic             xor_en_o,
  output logic [IDX_W-1:0] pend_idx_o,
  output logic             cap_en_o,
  output logic [IDX_W-1:0] base_o
);

  localparam logic [IDX_W-1:0]  MASK8 = IDX_W'(MAX_WORDS-1);
  localparam logic [IDX_W-1:0]  MASK4 = IDX_W'(MAX_WORDS/2-1);
  localparam logic [HALF_W-1:0] HL8   = HALF_W'(MAX_WORDS/2-1);
  localparam logic [HALF_W-1:0] HL4   = HALF_W'(MAX_WORDS/4-1);

  gfn_state_e        st_q, st_n;
  logic              m8_q, m8_n;
  logic [RND_W-1:0]  rlast_q, rlast_n;
  logic [IDX_W-1:0]  cnt_q, cnt_n;
  logic [RND_W-1:0]  rnd_q, rnd_n;
  logic [HALF_W-1:0] k_q, k_n;
  logic [IDX_W-1:0]  base_q, base_n;
  logic              pend_q, pend_n;
  logic [IDX_W-1:0]  pidx_q, pidx_n;

  logic [IDX_W-1:0]  nmask;
  logic [HALF_W-1:0] hlast;
  logic [IDX_W-1:0]  even_off;
  logic [IDX_W-1:0]  dst_idx;
  logic              take;

  always_comb begin
    nmask    = m8_q ? MASK8 : MASK4;
    hlast    = m8_q ? HL8 : HL4;
    even_off = IDX_W'({k_q, 1'b0});
    rd_idx_o = (base_q + even_off) & nmask;
    dst_idx  = (base_q + even_off + IDX_W'(1)) & nmask;
    rk_idx_o = m8_q ? (RK_W'(rnd_q) * RK_W'(MAX_WORDS/2) + RK_W'(k_q))
                    : (RK_W'(rnd_q) * RK_W'(MAX_WORDS/4) + RK_W'(k_q));
    sel_o    = k_q[0];
    take     = start_i && ((st_q == ST_IDLE) || (st_q == ST_DRAIN));
  end

  always_comb begin
    st_n     = st_q;
    m8_n     = m8_q;
    rlast_n  = rlast_q;
    cnt_n    = cnt_q;
    rnd_n    = rnd_q;
    k_n      = k_q;
    base_n   = base_q;
    pend_n   = 1'b0;
    pidx_n   = pidx_q;
    ld_en_o  = 1'b0;
    ld_idx_o = '0;
    iss_en_o = 1'b0;
    xor_en_o = 1'b0;
    cap_en_o = 1'b0;
    case (st_q)
      ST_IDLE: ;
      ST_LOAD: begin
        ld_en_o  = 1'b1;
        ld_idx_o = cnt_q;
        if (cnt_q == nmask) begin
          st_n   = ST_RUN;
          rnd_n  = '0;
          k_n    = '0;
          base_n = '0;
        end else begin
          cnt_n = cnt_q + IDX_W'(1);
        end
      end
      ST_RUN: begin
        iss_en_o = 1'b1;
        xor_en_o = pend_q;
        pend_n   = 1'b1;
        pidx_n   = dst_idx;
        if (k_q == hlast) begin
          k_n = '0;
          if (rnd_q == rlast_q) begin
            st_n = ST_DRAIN;
          end else begin
            rnd_n  = rnd_q + RND_W'(1);
            base_n = (base_q + IDX_W'(1)) & nmask;
          end
        end else begin
          k_n = k_q + HALF_W'(1);
        end
      end
      ST_DRAIN: begin
        cap_en_o = 1'b1;
        st_n     = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
    if (take) begin
      st_n     = ST_LOAD;
      m8_n     = mode8_i;
      rlast_n  = (ksel_i == 2'd0) ? RND_W'(RND_SHORT-1) :
                 (ksel_i == 2'd1) ? RND_W'(RND_MID-1) : RND_W'(RND_LONG-1);
      cnt_n    = IDX_W'(1);
      base_n   = '0;
      ld_en_o  = 1'b1;
      ld_idx_o = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      m8_q    <= 1'b0;
      rlast_q <= '0;
      cnt_q   <= '0;
      rnd_q   <= '0;
      k_q     <= '0;
      base_q  <= '0;
      pend_q  <= 1'b0;
      pidx_q  <= '0;
    end else begin
      st_q    <= st_n;
      m8_q    <= m8_n;
      rlast_q <= rlast_n;
      cnt_q   <= cnt_n;
      rnd_q   <= rnd_n;
      k_q     <= k_n;
      base_q  <= base_n;
      pend_q  <= pend_n;
      pidx_q  <= pidx_n;
    end
  end

  assign m8_o       = m8_q;
  assign busy_o     = (st_q != ST_IDLE);
  assign pend_idx_o = pidx_q;
  assign base_o     = base_q;

endmodule

// File: rtl/gfn_out_stage.sv
// Output stage: merges the last F result, undoes the base offset, whitens, registers.
module gfn_out_stage #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned OUT_W = (DEPTH/2)*WORD_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cap_en,
  input  logic                         m8,
  input  logic [IDX_W-1:0]             base,
  input  logic [IDX_W-1:0]             pend_idx,
  input  logic [WORD_W-1:0]            f_res,
  input  logic [DEPTH-1:0][WORD_W-1:0] words,
  input  logic [WORD_W-1:0]            wk_odd1,
  input  logic [WORD_W-1:0]            wk_odd3,
  output logic [OUT_W-1:0]             out_a_o,
  output logic [OUT_W-1:0]             out_b_o,
  output logic                         done_o
);

  localparam logic [IDX_W-1:0] MASK8 = IDX_W'(DEPTH-1);
  localparam logic [IDX_W-1:0] MASK4 = IDX_W'(DEPTH/2-1);

  logic [DEPTH-1:0][WORD_W-1:0] mrg;
  logic [DEPTH-1:0][WORD_W-1:0] lg;
  logic [IDX_W-1:0]             nmask;
  logic [OUT_W-1:0]             a_d, b_d, a_q, b_q;
  logic                         done_q;

  always_comb begin
    nmask = m8 ? MASK8 : MASK4;
    for (int j = 0; j < DEPTH; j++) begin
      mrg[j] = words[j] ^ ((IDX_W'(j) == pend_idx) ? f_res : '0);
    end
    for (int i = 0; i < DEPTH; i++) begin
      lg[i] = mrg[(base + IDX_W'(i)) & nmask];
    end
    if (!m8) begin
      lg[1] = lg[1] ^ wk_odd1;
      lg[3] = lg[3] ^ wk_odd3;
    end
    for (int i = 0; i < DEPTH/2; i++) begin
      a_d[(DEPTH/2-1-i)*WORD_W +: WORD_W] = lg[i];
      b_d[(DEPTH/2-1-i)*WORD_W +: WORD_W] = m8 ? lg[DEPTH/2+i] : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q    <= '0;
      b_q    <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= cap_en;
      if (cap_en) begin
        a_q <= a_d;
        b_q <= b_d;
      end
    end
  end

  assign out_a_o = a_q;
  assign out_b_o = b_q;
  assign done_o  = done_q;

endmodule

// File: rtl/gfn_fold_core.sv
// Folded 4/8-branch Feistel datapath, top level.
module gfn_fold_core #(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned MAX_WORDS = 8,
  parameter int unsigned RND_SHORT = 18,
  parameter int unsigned RND_MID   = 22,
  parameter int unsigned RND_LONG  = 26,
  localparam int unsigned IDX_W = $clog2(MAX_WORDS),
  localparam int unsigned RK_W  = $clog2(RND_LONG*MAX_WORDS/2),
  localparam int unsigned OUT_W = (MAX_WORDS/2)*WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              mode8_i,
  input  logic [1:0]        ksel_i,
  input  logic [WORD_W-1:0] din_i,
  input  logic [WORD_W-1:0] wk0_i,
  input  logic [WORD_W-1:0] wk1_i,
  input  logic [WORD_W-1:0] wk2_i,
  input  logic [WORD_W-1:0] wk3_i,
  output logic              rk_req_o,
  output logic [RK_W-1:0]   rk_idx_o,
  input  logic [WORD_W-1:0] rk_i,
  output logic              f_req_o,
  output logic              f_sel_o,
  output logic [WORD_W-1:0] f_arg_o,
  input  logic [WORD_W-1:0] f_res_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [OUT_W-1:0]  out_a_o,
  output logic [OUT_W-1:0]  out_b_o
);

  logic                            m8;
  logic                            ld_en, iss_en, xor_en, cap_en;
  logic [IDX_W-1:0]                ld_idx, rd_idx, pend_idx, base;
  logic [WORD_W-1:0]               ld_data, rd_data, white;
  logic [MAX_WORDS-1:0][WORD_W-1:0] words;

  gfn_sched #(
    .MAX_WORDS(MAX_WORDS), .RND_SHORT(RND_SHORT),
    .RND_MID(RND_MID), .RND_LONG(RND_LONG)
  ) sched_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode8_i(mode8_i),
    .ksel_i(ksel_i), .m8_o(m8), .busy_o(busy_o), .ld_en_o(ld_en),
    .ld_idx_o(ld_idx), .iss_en_o(iss_en), .sel_o(f_sel_o),
    .rd_idx_o(rd_idx), .rk_idx_o(rk_idx_o), .xor_en_o(xor_en),
    .pend_idx_o(pend_idx), .cap_en_o(cap_en), .base_o(base)
  );

  // Pre-whitening of the odd words in 4-branch mode only.
  always_comb begin
    white = '0;
    if (!m8 && (ld_idx == IDX_W'(1))) white = wk0_i;
    if (!m8 && (ld_idx == IDX_W'(3))) white = wk1_i;
    ld_data = din_i ^ white;
  end

  gfn_word_store #(.WORD_W(WORD_W), .DEPTH(MAX_WORDS)) store_i (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_idx(ld_idx),
    .ld_data(ld_data), .xor_en(xor_en), .xor_idx(pend_idx),
    .xor_data(f_res_i), .rd_idx(rd_idx), .rd_data(rd_data), .all_o(words)
  );

  gfn_out_stage #(.WORD_W(WORD_W), .DEPTH(MAX_WORDS)) outs_i (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .m8(m8), .base(base),
    .pend_idx(pend_idx), .f_res(f_res_i), .words(words),
    .wk_odd1(wk2_i), .wk_odd3(wk3_i), .out_a_o(out_a_o),
    .out_b_o(out_b_o), .done_o(done_o)
  );

  assign rk_req_o = iss_en;
  assign f_req_o  = iss_en;
  assign f_arg_o  = rd_data ^ rk_i;

endmodule

// File: rtl/gfn_fold_chk.sv
// Protocol checker bound to the top module.
module gfn_fold_chk #(
  parameter int unsigned MAX_WORDS = 8,
  parameter int unsigned RND_LONG  = 26,
  localparam int unsigned RK_W = $clog2(RND_LONG*MAX_WORDS/2)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_i,
  input logic            busy_o,
  input logic            done_o,
  input logic            rk_req_o,
  input logic [RK_W-1:0] rk_idx_o,
  input logic            f_sel_o
);

  // R7: the result strobe lasts one cycle
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7: a result only follows a busy cycle
  p_done_after_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(busy_o));

  // R8: no key request while idle
  p_req_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rk_req_o |-> busy_o);

  // R8: an accepted start from idle makes the block busy
  p_start_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  // R6: key indices begin at zero
  p_idx_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rk_req_o) |-> (rk_idx_o == '0));

  // R6: key indices advance by one per request
  p_idx_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rk_req_o && $past(rk_req_o)) |-> (rk_idx_o == RK_W'($past(rk_idx_o) + 1'b1)));

  // R6: F0 and F1 alternate with the key index
  p_sel_parity_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rk_req_o |-> (f_sel_o == rk_idx_o[0]));

endmodule

bind gfn_fold_core gfn_fold_chk #(.MAX_WORDS(MAX_WORDS), .RND_LONG(RND_LONG)) chk_i (.*);

// File: tb/gfn_fold_core_tb.sv
module gfn_fold_core_tb_top;

  logic         clk;
  logic         rst_n;
  logic         start_i;
  logic         mode8_i;
  logic [1:0]   ksel_i;
  logic [31:0]  din_i;
  logic [31:0]  wk0_i, wk1_i, wk2_i, wk3_i;
  logic         rk_req_o;
  logic [6:0]   rk_idx_o;
  logic [31:0]  rk_i;
  logic         f_req_o;
  logic         f_sel_o;
  logic [31:0]  f_arg_o;
  logic [31:0]  f_res_i;
  logic         busy_o;
  logic         done_o;
  logic [127:0] out_a_o;
  logic [127:0] out_b_o;

  int n_chk;
  int n_fail;
  int rk_cnt;

  gfn_fold_core dut_i (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] f_fn(input logic sel, input logic [31:0] a);
    if (sel) f_fn = {a[20:0], a[31:21]} + 32'h9E37_79B9;
    else     f_fn = {a[24:0], a[31:25]} ^ 32'h5A82_7999 ^ {a[7:0], 24'h0};
  endfunction

  function automatic logic [31:0] rk_fn(input logic [6:0] i);
    rk_fn = ({25'h0, i} * 32'h0100_0193) ^ 32'hC3A5_1F00;
  endfunction

  assign rk_i = rk_fn(rk_idx_o);
  always @(posedge clk) f_res_i <= f_fn(f_sel_o, f_arg_o);
  always @(posedge clk) if (rk_req_o) rk_cnt <= rk_cnt + 1;

  function automatic int rounds_of(input logic [1:0] ks);
    rounds_of = (ks == 2'd0) ? 18 : (ks == 2'd1) ? 22 : 26;
  endfunction

  function automatic logic [31:0] wd(input logic [255:0] d, input int i);
    wd = d[255-32*i -: 32];
  endfunction

  // Reference model built from the requirements (R2, R3, R4, R5, R10).
  task automatic ref_model(input logic m8, input logic [1:0] ks, input logic [255:0] d,
                           output logic [127:0] ea, output logic [127:0] eb);
    logic [31:0] t [8];
    logic [31:0] tmp;
    int n, h, r_n;
    n = m8 ? 8 : 4;
    h = n / 2;
    r_n = rounds_of(ks);
    for (int i = 0; i < 8; i++) t[i] = wd(d, i);
    if (!m8) begin
      t[1] = t[1] ^ wk0_i;
      t[3] = t[3] ^ wk1_i;
    end
    for (int r = 0; r < r_n; r++) begin
      for (int k = 0; k < h; k++)
        t[2*k+1] = t[2*k+1] ^ f_fn(k[0], t[2*k] ^ rk_fn(7'(r*h+k)));
      if (r != r_n - 1) begin
        tmp = t[0];
        for (int i = 0; i < n - 1; i++) t[i] = t[i+1];
        t[n-1] = tmp;
      end
    end
    if (!m8) begin
      t[1] = t[1] ^ wk2_i;
      t[3] = t[3] ^ wk3_i;
    end
    ea = {t[0], t[1], t[2], t[3]};
    eb = m8 ? {t[4], t[5], t[6], t[7]} : 128'h0;
  endtask

  task automatic chk(input bit ok, input string req, input logic [255:0] act,
                     input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [255:0] pat(input int p);
    logic [255:0] d;
    for (int i = 0; i < 8; i++) begin
      case (p)
        0: d[255-32*i -: 32] = 32'h0;
        1: d[255-32*i -: 32] = 32'hFFFF_FFFF;
        2: d[255-32*i -: 32] = 32'h1111_1111 * (i + 1);
        default: d[255-32*i -: 32] = 32'h1 << ((i * 5 + p) % 32);
      endcase
    end
    pat = d;
  endfunction

  task automatic set_wk(input int p);
    wk0_i = 32'h0F1E_2D3C ^ p;
    wk1_i = 32'h4B5A_6978 + p;
    wk2_i = 32'h8796_A5B4 ^ (p << 8);
    wk3_i = 32'hC3D2_E1F0 - p;
  endtask

  // One block; poke injects an ignored start during the rounds (R8).
  task automatic run_blk(input logic m8, input logic [1:0] ks, input logic [255:0] d,
                         input bit poke);
    logic [127:0] ea, eb;
    int n, h, r_n, waited, exp_wait;
    bit busy_seen;
    ref_model(m8, ks, d, ea, eb);
    n = m8 ? 8 : 4;
    h = n / 2;
    r_n = rounds_of(ks);
    exp_wait = n + r_n * h + 1;
    @(negedge clk);
    rk_cnt = 0;
    start_i = 1'b1; mode8_i = m8; ksel_i = ks; din_i = wd(d, 0);
    waited = 0;
    busy_seen = 1'b0;
    for (int i = 1; i < n; i++) begin
      @(negedge clk);
      waited++;
      if (i == 1) busy_seen = busy_o;
      start_i = 1'b0;
      din_i = wd(d, i);
    end
    while (1) begin
      @(negedge clk);
      waited++;
      start_i = 1'b0;
      if (poke && waited == n + 2) begin
        start_i = 1'b1; mode8_i = ~m8; din_i = 32'hDEAD_BEEF;
      end
      if (done_o || waited > 600) break;
    end
    // R5 and R7: latency follows the round count
    chk(waited == exp_wait, "R7", 256'(waited), 256'(exp_wait));
    chk(out_a_o == ea, m8 ? "R4" : "R3", 256'(out_a_o), 256'(ea));
    chk(out_b_o == eb, m8 ? "R4" : "R10", 256'(out_b_o), 256'(eb));
    chk(rk_cnt == r_n * h, "R6", 256'(rk_cnt), 256'(r_n * h));
    if (!m8 && ks == 2'd0) chk(busy_seen, "R8", 256'(busy_seen), 256'(1));
    if (poke) chk(out_a_o == ea && waited == exp_wait, "R8", 256'(out_a_o), 256'(ea));
    @(negedge clk);
    chk(!done_o, "R7", 256'(done_o), 256'(0));
  endtask

  // Overlapped start in the drain cycle (R9).
  task automatic run_overlap();
    logic [127:0] ea_a, eb_a, ea_b, eb_b;
    logic [255:0] da, db;
    int waited;
    da = pat(2);
    db = pat(3);
    ref_model(1'b0, 2'd0, da, ea_a, eb_a);
    ref_model(1'b1, 2'd1, db, ea_b, eb_b);
    @(negedge clk);
    start_i = 1'b1; mode8_i = 1'b0; ksel_i = 2'd0; din_i = wd(da, 0);
    waited = 0;
    while (waited < 4 + 18 * 2) begin
      @(negedge clk);
      waited++;
      start_i = 1'b0;
      if (waited < 4) din_i = wd(da, waited);
    end
    chk(busy_o && !done_o, "R9", 256'({busy_o, done_o}), 256'(2'b10));
    start_i = 1'b1; mode8_i = 1'b1; ksel_i = 2'd1; din_i = wd(db, 0);
    waited = 0;
    @(negedge clk);
    waited++;
    chk(done_o && out_a_o == ea_a, "R9", 256'(out_a_o), 256'(ea_a));
    start_i = 1'b0;
    din_i = wd(db, 1);
    while (1) begin
      @(negedge clk);
      waited++;
      if (waited < 8) din_i = wd(db, waited);
      if (done_o || waited > 600) break;
    end
    chk(waited == 8 + 22 * 4 + 1, "R9", 256'(waited), 256'(97));
    chk(out_a_o == ea_b && out_b_o == eb_b, "R9", {out_a_o, out_b_o}, {ea_b, eb_b});
  endtask

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; start_i = 1'b0; mode8_i = 1'b0; ksel_i = 2'd0; din_i = '0;
    set_wk(0);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy_o && !done_o && !rk_req_o && !f_req_o, "R1",
        256'({busy_o, done_o, rk_req_o, f_req_o}), 256'(0));
    chk(out_a_o == '0 && out_b_o == '0, "R1", {out_a_o, out_b_o}, 256'(0));
    rst_n = 1'b1;
    @(negedge clk);
    for (int m = 0; m < 2; m++) begin
      for (int ks = 0; ks < 4; ks++) begin
        for (int p = 0; p < 4; p++) begin
          set_wk(p + 4 * ks);
          run_blk(m[0], ks[1:0], pat(p), p == 2);
        end
      end
    end
    set_wk(7);
    run_overlap();
    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule